// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a bus target for a two-wire serial bus with 7-bit addressing. It sits in front of a register space of 64 bytes that belongs to the surrounding logic. SCL and SDA are taken in through a synchronizer and a glitch filter. The block then recognises START and STOP conditions, checks the device address and moves bytes between the bus and the register space. An internal pointer chooses the register that is touched, and it advances by one after every data byte, whether that byte is written or read.

A write transaction carries the device address, then one pointer byte, then any number of data bytes. Each data byte comes out of the block as a one-cycle write strobe together with an address and a data value. A read transaction streams bytes starting at the current pointer. It is usually preceded by a pointer-only write and a repeated START. The register storage sits outside the block and answers a read address with data in the same cycle. The block drives SDA only as an open-drain enable. A power-fail input stops any transfer and returns the pointer to zero.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block acknowledges only the address byte 8'hD0 (write) or 8'hD1 (read). That is the 7-bit address 7'b1101000 in bits 7..1, with bit 0 = 1 meaning read. To acknowledge, it asserts sda_oe_o (pulls SDA low) through the ninth SCL clock. For any other address it sends no acknowledge, and it ignores every byte until the next START.
- R2: In a write transaction, the first byte after the address loads the pointer from its low 6 bits and produces no write strobe.
- R3: Each later byte of a write is acknowledged and produces exactly one rb_we_o pulse, with rb_addr_o equal to the pointer and rb_wdata_o equal to the byte. The pointer then advances by one.
- R4: In a read transaction, the block shifts out rb_rdata_i for the current pointer, MSB first, changing SDA only while SCL is low. The pointer advances by one after each byte.
- R5: The pointer wraps from 63 to 0, for writes and for reads.
- R6: A NACK from the master (SDA high in the ninth clock of a read byte) ends the read. SDA then stays released until the next START.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point restarts the address phase. A STOP releases SDA and returns the block to idle.
- R8: While pwr_fail_i is high, the transfer is aborted, the pointer is held at 0, no acknowledge or write strobe is produced, and bus activity is ignored.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN (default 3) clock cycles is ignored.
- R10: After reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pwr_fail_i | input | 1 | Power-fail abort, active high |
| rb_addr_o | output | PTR_W | Register address (the current pointer) |
| rb_we_o | output | 1 | One-cycle write strobe |
| rb_wdata_o | output | 8 | Write data |
| rb_rdata_i | input | 8 | Read data for rb_addr_o, valid in the same cycle |

## Verification
On every cycle, the assertions check the following: SDA never changes while the filtered SCL is high, a STOP always releases SDA, the pointer steps by exactly one after each write strobe and wraps at the top, and power-fail zeroes the pointer and silences the bus. Other behaviours can only be shown by the bench's scenarios, because they span whole transactions. These are the address match and its refusal of foreign addresses, pointer loading, data read back after repeated START, burst wrap across 63 to 0, reads ended by NACK, and SCL glitch rejection.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } rb_state_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } rb_kind_e;
endpackage

// File: rtl/i2c_rb_deglitch.sv
module i2c_rb_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_pass
      assign dout = synced;
   end else begin : g_filt
      // the output only moves once FILT_LEN samples agree
      logic [FILT_LEN-1:0] hist;
      logic                lvl;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist <= '1;
            lvl  <= 1'b1;
         end else begin
            hist <= {hist[FILT_LEN-2:0], synced};
            if (&hist)       lvl <= 1'b1;
            else if (~|hist) lvl <= 1'b0;
         end
      end
      assign dout = lvl;
   end
endmodule

// File: rtl/i2c_rb_busev.sv
module i2c_rb_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
   import i2c_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h68,
   parameter int         PTR_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_in,
   input  logic [7:0]       rb_rdata,
   output logic             sda_oe,
   output logic [PTR_W-1:0] rb_addr,
   output logic             rb_we,
   output logic [7:0]       rb_wdata
);
   rb_state_e        state;
   rb_kind_e         kind;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic [PTR_W-1:0] ptr;
   logic             rd_mode;
   logic             mst_nack;
   logic             wr_q;
   logic [7:0]       wdat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind     <= BK_ADDR;
         bitcnt   <= '0;
         shreg    <= '0;
         ptr      <= '0;
         rd_mode  <= 1'b0;
         mst_nack <= 1'b0;
         wr_q     <= 1'b0;
         wdat     <= '0;
      end else if (pwr_fail) begin
         state  <= ST_IDLE;
         ptr    <= '0;
         wr_q   <= 1'b0;
         bitcnt <= '0;
      end else begin
         wr_q <= 1'b0;
         if (wr_q) ptr <= ptr + 1'b1;
         if (start_det) begin
            state  <= ST_RX;
            kind   <= BK_ADDR;
            bitcnt <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_in};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     case (kind)
                        BK_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rd_mode <= shreg[0];
                              state   <= ST_RX_ACK;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        BK_PTR: begin
                           ptr   <= shreg[PTR_W-1:0];
                           state <= ST_RX_ACK;
                        end
                        default: begin
                           wr_q  <= 1'b1;
                           wdat  <= shreg;
                           state <= ST_RX_ACK;
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (kind == BK_ADDR && rd_mode) begin
                        state <= ST_TX;
                        shreg <= rb_rdata;
                     end else begin
                        state <= ST_RX;
                        kind  <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        state <= ST_TX_ACK;
                        ptr   <= ptr + 1'b1;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mst_nack <= sda_in;
                  end else if (scl_fall) begin
                     if (mst_nack) begin
                        state <= ST_IDLE;
                     end else begin
                        state  <= ST_TX;
                        shreg  <= rb_rdata;
                        bitcnt <= '0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = (state == ST_RX_ACK) || (state == ST_TX && !shreg[7]);
   assign rb_addr  = ptr;
   assign rb_we    = wr_q;
   assign rb_wdata = wdat;
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         PTR_W       = 6,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic             pwr_fail_i,
   output logic [PTR_W-1:0] rb_addr_o,
   output logic             rb_we_o,
   output logic [7:0]       rb_wdata_o,
   input  logic [7:0]       rb_rdata_i
);
   localparam int DEPTH = 1 << PTR_W;

   if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
      $error("PTR_W must lie in 1..8");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("register space too small");
   end

   logic [1:0] line_raw, line_flt;
   logic       scl_flt, sda_flt;
   logic       ev_rise, ev_fall, ev_start, ev_stop;

   assign line_raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_rb_deglitch #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) u_dg (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (line_raw[g]),
         .dout (line_flt[g])
      );
   end

   assign scl_flt = line_flt[1];
   assign sda_flt = line_flt[0];

   i2c_rb_busev u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_flt),
      .sda      (sda_flt),
      .scl_rise (ev_rise),
      .scl_fall (ev_fall),
      .start_det(ev_start),
      .stop_det (ev_stop)
   );

   i2c_rb_engine #(
      .DEV_ADDR(DEV_ADDR),
      .PTR_W   (PTR_W)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_fail (pwr_fail_i),
      .scl_rise (ev_rise),
      .scl_fall (ev_fall),
      .start_det(ev_start),
      .stop_det (ev_stop),
      .sda_in   (sda_flt),
      .rb_rdata (rb_rdata_i),
      .sda_oe   (sda_oe_o),
      .rb_addr  (rb_addr_o),
      .rb_we    (rb_we_o),
      .rb_wdata (rb_wdata_o)
   );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
   parameter int PTR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_fail_i,
   input logic             sda_oe_o,
   input logic             rb_we_o,
   input logic [PTR_W-1:0] rb_addr_o,
   input logic             scl_flt,
   input logic             ev_stop
);
   // R4 / R7: SDA may only move while SCL is low
   p_sda_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_flt && $past(scl_flt) && !pwr_fail_i && !$past(pwr_fail_i)) |-> $stable(sda_oe_o));

   p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && !pwr_fail_i) |=> !sda_oe_o);

   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_we_o && !pwr_fail_i) |=> rb_addr_o == $past(rb_addr_o) + 1'b1);

   p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_we_o && rb_addr_o == {PTR_W{1'b1}} && !pwr_fail_i) |=> rb_addr_o == '0);

   p_pf_ptr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_fail_i) |-> rb_addr_o == '0);

   p_pf_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail_i && $past(pwr_fail_i)) |-> (!sda_oe_o && !rb_we_o));

   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sda_oe_o && !rb_we_o));
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_fail_i(pwr_fail_i),
   .sda_oe_o  (sda_oe_o),
   .rb_we_o   (rb_we_o),
   .rb_addr_o (rb_addr_o),
   .scl_flt   (scl_flt),
   .ev_stop   (ev_stop)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
   localparam int Q = 10;   // quarter bit period in clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       pf = 1'b0;
   logic       sda_oe;
   logic [5:0] rb_addr;
   logic       rb_we;
   logic [7:0] rb_wdata;
   logic [7:0] rb_rdata;
   wire        sda_line = m_sda & ~sda_oe;

   logic [7:0] mem [64];
   int         wcnt = 0;
   logic [5:0] last_waddr = '0;
   logic [7:0] last_wdata = '0;
   int         total = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_regbank_target u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_oe_o  (sda_oe),
      .pwr_fail_i(pf),
      .rb_addr_o (rb_addr),
      .rb_we_o   (rb_we),
      .rb_wdata_o(rb_wdata),
      .rb_rdata_i(rb_rdata)
   );

   // register storage model owned by the surrounding logic
   assign rb_rdata = mem[rb_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 64; k++) mem[k] <= 8'h00;
      end else if (rb_we) begin
         mem[rb_addr] <= rb_wdata;
         wcnt         <= wcnt + 1;
         last_waddr   <= rb_addr;
         last_wdata   <= rb_wdata;
      end
   end

   localparam logic [13:0] VEC [6] = '{
      {6'd3,  8'hA5}, {6'd17, 8'h5A}, {6'd40, 8'h00},
      {6'd63, 8'hFF}, {6'd1,  8'h81}, {6'd50, 8'h3C}
   };

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wclk(Q);
      m_scl = 1'b1; wclk(Q);
      m_sda = 1'b0; wclk(Q);
      m_scl = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wclk(Q);
      m_scl = 1'b1; wclk(Q);
      m_sda = 1'b1; wclk(Q);
   endtask

   task automatic tx(input logic [7:0] b, output logic ack, input int glitch_bit = -1);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i];
         if (i == glitch_bit) begin
            wclk(4); m_scl = 1'b1; wclk(1); m_scl = 1'b0; wclk(5);
         end else begin
            wclk(Q);
         end
         m_scl = 1'b1; wclk(2*Q);
         m_scl = 1'b0; wclk(Q);
      end
      m_sda = 1'b1; wclk(Q);
      m_scl = 1'b1; wclk(Q);
      ack = ~sda_line;
      wclk(Q);
      m_scl = 1'b0; wclk(Q);
   endtask

   task automatic rx(output logic [7:0] b, input logic nack);
      for (int i = 7; i >= 0; i--) begin
         wclk(Q);
         m_scl = 1'b1; wclk(Q);
         b[i] = sda_line;
         wclk(Q);
         m_scl = 1'b0; wclk(Q);
      end
      m_sda = nack; wclk(Q);
      m_scl = 1'b1; wclk(2*Q);
      m_scl = 1'b0; wclk(Q);
      m_sda = 1'b1;
   endtask

   initial begin
      logic       a0, a1, a2, a3;
      logic [7:0] d0, d1, d2;
      int         w0;

      wclk(10);
      rst_n = 1'b1;
      wclk(5);
      chk("R10 sda released after reset", sda_oe, 0);
      chk("R10 no write strobe after reset", rb_we, 0);

      // table of single writes, each read back through a random read
      for (int v = 0; v < 6; v++) begin
         logic [5:0] p;
         logic [7:0] dv;
         p  = VEC[v][13:8];
         dv = VEC[v][7:0];
         w0 = wcnt;
         bus_start();
         tx(8'hD0, a0); tx({2'b00, p}, a1); tx(dv, a2);
         bus_stop();
         chk("R1 R3 acks on address, pointer and data", {a0, a1, a2}, 3'b111);
         chk("R2 R3 one strobe at loaded pointer",
             {wcnt - w0, 2'b00, last_waddr, last_wdata}, {32'd1, 2'b00, p, dv} >> 0 & 32'hFFFFFFFF);
         bus_start();
         tx(8'hD0, a0); tx({2'b00, p}, a1);
         bus_start();
         tx(8'hD1, a2); rx(d0, 1'b1);
         bus_stop();
         chk("R4 read back after repeated START", {a0, a1, a2, d0}, {3'b111, dv});
      end

      // burst write across the top of the space
      w0 = wcnt;
      bus_start();
      tx(8'hD0, a0); tx(8'd62, a1); tx(8'h11, a2); tx(8'h22, a3); tx(8'h33, a0);
      bus_stop();
      chk("R5 burst write strobes", wcnt - w0, 3);
      chk("R5 third burst byte wrapped to address 0", {last_waddr, last_wdata}, {6'd0, 8'h33});
      bus_start();
      tx(8'hD0, a0); tx(8'd62, a1);
      bus_start();
      tx(8'hD1, a2);
      rx(d0, 1'b0); rx(d1, 1'b0); rx(d2, 1'b1);
      bus_stop();
      chk("R4 R5 burst read 62,63,0", {d0, d1, d2}, 24'h112233);
      wclk(Q);
      chk("R7 sda released after STOP", sda_oe, 0);

      // foreign address is ignored
      w0 = wcnt;
      bus_start();
      tx(8'hA0, a0); tx(8'h05, a1); tx(8'h55, a2);
      bus_stop();
      chk("R1 no ack for foreign address or its bytes", {a0, a1, a2}, 3'b000);
      chk("R1 no write after foreign address", wcnt - w0, 0);

      // NACK ends a read
      bus_start();
      tx(8'hD0, a0); tx(8'd3, a1);
      bus_start();
      tx(8'hD1, a2); rx(d0, 1'b1);
      rx(d1, 1'b1);
      chk("R6 first byte before NACK", d0, 8'hA5);
      chk("R6 bus stays released after NACK", {d1, sda_oe}, {8'hFF, 1'b0});
      bus_stop();

      // power-fail aborts and zeroes the pointer
      w0 = wcnt;
      bus_start();
      tx(8'hD0, a0); tx(8'd5, a1);
      pf = 1'b1;
      wclk(2);
      tx(8'h77, a2);
      chk("R8 acks before power-fail, none during", {a0, a1, a2}, 3'b110);
      bus_stop();
      bus_start();
      tx(8'hD1, a3);
      chk("R8 address ignored while power-fail high", a3, 0);
      bus_stop();
      chk("R8 no write during power-fail", wcnt - w0, 0);
      pf = 1'b0;
      wclk(Q);
      bus_start();
      tx(8'hD1, a0); rx(d0, 1'b1);
      bus_stop();
      chk("R8 current-address read starts at 0", {a0, d0}, {1'b1, 8'h33});

      // SCL glitch inside a data byte is filtered out
      w0 = wcnt;
      bus_start();
      tx(8'hD0, a0); tx(8'd30, a1); tx(8'hC3, a2, 5);
      bus_stop();
      chk("R9 single strobe despite glitch", {wcnt - w0, 2'b00, last_waddr, last_wdata},
          {32'd1, 2'b00, 6'd30, 8'hC3});
      bus_start();
      tx(8'hD0, a0); tx(8'd30, a1);
      bus_start();
      tx(8'hD1, a2); rx(d0, 1'b1);
      bus_stop();
      chk("R9 data intact after glitch", d0, 8'hC3);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule